// File: doc/BRIEF.md
# Serial EEPROM Target with Page Programming

This block is a two-wire serial bus target that sits in front of a byte-wide storage array of 4,096 or 8,192 locations. The array size is set by a parameter. The block samples the system-clock-domain copies of SCL and SDA through a short synchroniser. It finds bus START and STOP conditions, checks the device address byte against three strap inputs, and acknowledges on SDA using an open-drain style enable: the block pulls the line low or lets it float.

After a write-type address byte, the master sends two pointer bytes and then data bytes. Data bytes go into a 32-byte page buffer rather than straight into the array. A STOP that follows at least one data byte starts a timed internal write cycle. During that cycle the staged bytes are moved into the array, and the block ignores its own address, so a master can poll for completion.

A read-type address byte returns bytes from the current pointer, one after another, until the master answers a byte with NACK. A high level on the write-protect input makes every write a no-op for the array. The bus handshake is left unchanged.

Top module: `eeprom_i2c_target`

## Requirements
- R1: While reset is held and right after it is released, the SDA pull-down enable is 0.
- R2: The device acknowledges only an address byte whose upper four bits are 1010 and whose next three bits equal the strap inputs. The strap is taken MSB first, and the last bit is read (1) or write (0). For any other address byte it leaves SDA released through the acknowledge bit and the rest of the transfer.
- R3: The SDA pull-down enable only turns on while the synchronised SCL is low. It stays off whenever the master is sending address, pointer or data bits.
- R4: After a write-type address byte, the next two bytes set the pointer, high byte first. Pointer bits at or above the array size (bit 12 for 4,096 bytes) are dropped, so high byte 0xF3 with low byte 0x45 selects location 0x345.
- R5: The pointer advances by one after each data byte. A later read that sends no pointer bytes continues from where the previous transfer left it.
- R6: A sequential read that passes the last location continues at location 0.
- R7: The page buffer holds 32 bytes. During a write, only the low five pointer bits advance. A byte past the page end wraps to the page start and replaces the byte staged there.
- R8: A STOP that follows one or more data bytes starts the internal write cycle, and only after it does the data appear on reads. A write transfer with a pointer but no data starts no cycle.
- R9: For WRITE_TICKS clock cycles after the STOP that starts a write cycle, the device does not acknowledge its address. After that it acknowledges again.
- R10: With the write-protect input high, every byte of a write is still acknowledged. No write cycle starts, so the device acknowledges its address at once, and the array keeps its old contents.
- R11: When the master answers a read byte with NACK, the block stops driving and SDA stays released until the next START.
- R12: A repeated START after the pointer bytes, followed by a read-type address byte, reads from the pointer just loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level |
| sdaOe | output | 1 | 1 pulls SDA low, 0 releases it |
| strap | input | 3 | Device address strap bits |
| writeProtect | input | 1 | High blocks all array programming |

## Verification
Two things can meet in one cycle: the STOP that ends a write and starts the busy cycle, and the address-acknowledge decision of the next transfer, which reads that busy state. The bench provokes this by polling with the device address straight after each committing STOP, and expects a NACK, then an ACK once the cycle has run out. A second overlap comes from page-buffer slot reuse. A 36-byte write that starts four bytes before a page end stages two bytes into the same slot. The read-back must show the later byte in every slot.

// File: rtl/eep_pkg.sv
package eep_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_ADRH,
    ST_ADRL,
    ST_WDATA,
    ST_RDATA,
    ST_WAIT
  } busState_t;

  // Strobes from bus control to the datapath, valid for one clock.
  typedef struct packed {
    logic       devWrite;
    logic       loadHi;
    logic       loadLo;
    logic       wrData;
    logic       rdAdv;
    logic       stopSeen;
    logic [7:0] byteVal;
  } ctrlStrobe_t;

endpackage

// File: rtl/eep_bus_ctrl.sv
module eep_bus_ctrl
  import eep_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  logic [2:0]  strap,
  input  logic        busy,
  input  logic [7:0]  rdData,
  output logic        sdaOe,
  output logic        sclLevel,
  output ctrlStrobe_t stb
);

  localparam logic [3:0] DEV_TYPE = 4'b1010;
  localparam logic [3:0] LAST_BIT = 4'd8;
  localparam logic [3:0] ACK_BIT  = 4'd9;

  // Two-stage synchronisers plus one history stage for edge detection.
  logic [1:0] sclSr, sdaSr;
  logic       sclPrev, sdaPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSr   <= 2'b11;
      sdaSr   <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSr   <= {sclSr[0], sclIn};
      sdaSr   <= {sdaSr[0], sdaIn};
      sclPrev <= sclSr[1];
      sdaPrev <= sdaSr[1];
    end
  end

  logic sclS, sdaS;
  assign sclS = sclSr[1];
  assign sdaS = sdaSr[1];
  assign sclLevel = sclS;

  logic sclRise, sclFall, startEvt, stopEvt;
  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startEvt = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopEvt  = sclS & sclPrev & ~sdaPrev & sdaS;

  busState_t  state;
  logic [3:0] bitCnt;
  logic [7:0] shreg;
  logic [7:0] rdByte;
  logic       rwRead;
  logic       mNack;

  logic matchDev;
  assign matchDev = (shreg[7:4] == DEV_TYPE) && (shreg[3:1] == strap) && !busy;

  logic inFrame;
  assign inFrame = (state != ST_IDLE) && (state != ST_WAIT);

  // Strobe decode: same-cycle pulses on the SCL falling edge that closes a byte.
  always_comb begin
    stb          = '0;
    stb.byteVal  = shreg;
    stb.stopSeen = stopEvt;
    if (!startEvt && !stopEvt && inFrame && sclFall) begin
      if (bitCnt == LAST_BIT) begin
        unique case (state)
          ST_DEV:   stb.devWrite = matchDev && !shreg[0];
          ST_ADRH:  stb.loadHi   = 1'b1;
          ST_ADRL:  stb.loadLo   = 1'b1;
          ST_WDATA: stb.wrData   = 1'b1;
          default:  ;
        endcase
      end else if (bitCnt == ACK_BIT) begin
        stb.rdAdv = ((state == ST_DEV) && rwRead) || ((state == ST_RDATA) && !mNack);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      shreg  <= '0;
      rdByte <= '0;
      rwRead <= 1'b0;
      mNack  <= 1'b0;
      sdaOe  <= 1'b0;
    end else if (startEvt) begin
      state  <= ST_DEV;
      bitCnt <= '0;
      sdaOe  <= 1'b0;
    end else if (stopEvt) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      sdaOe  <= 1'b0;
    end else if (inFrame) begin
      if (sclRise) begin
        bitCnt <= bitCnt + 1'b1;
        if (bitCnt < LAST_BIT && state != ST_RDATA) begin
          shreg <= {shreg[6:0], sdaS};
        end
        if (bitCnt == LAST_BIT) begin
          mNack <= sdaS;
        end
      end
      if (sclFall) begin
        if (bitCnt == LAST_BIT) begin
          if (state == ST_RDATA) begin
            sdaOe <= 1'b0;
          end else if (state == ST_DEV && !matchDev) begin
            state <= ST_WAIT;
          end else begin
            sdaOe <= 1'b1;
            if (state == ST_DEV) begin
              rwRead <= shreg[0];
            end
          end
        end else if (bitCnt == ACK_BIT) begin
          bitCnt <= '0;
          unique case (state)
            ST_DEV: begin
              if (rwRead) begin
                state  <= ST_RDATA;
                rdByte <= rdData;
                sdaOe  <= ~rdData[7];
              end else begin
                state <= ST_ADRH;
                sdaOe <= 1'b0;
              end
            end
            ST_ADRH: begin
              state <= ST_ADRL;
              sdaOe <= 1'b0;
            end
            ST_ADRL: begin
              state <= ST_WDATA;
              sdaOe <= 1'b0;
            end
            ST_RDATA: begin
              if (mNack) begin
                state <= ST_WAIT;
                sdaOe <= 1'b0;
              end else begin
                rdByte <= rdData;
                sdaOe  <= ~rdData[7];
              end
            end
            default: sdaOe <= 1'b0;
          endcase
        end else if (state == ST_RDATA && bitCnt != 4'd0) begin
          sdaOe <= ~rdByte[3'd7 - bitCnt[2:0]];
        end
      end
    end
  end

endmodule

// File: rtl/eep_datapath.sv
module eep_datapath
  import eep_pkg::*;
#(
  parameter int MEM_BYTES   = 4096,
  parameter int PAGE_BYTES  = 32,
  parameter int WRITE_TICKS = 300000
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctrlStrobe_t                  stb,
  input  logic                         writeProtect,
  output logic [7:0]                   rdData,
  output logic                         busy,
  output logic [$clog2(MEM_BYTES)-1:0] curPtr
);

  localparam int AW    = $clog2(MEM_BYTES);
  localparam int PW    = $clog2(PAGE_BYTES);
  localparam int HW    = AW - 8;
  localparam int TICKS = (WRITE_TICKS < PAGE_BYTES) ? PAGE_BYTES : WRITE_TICKS;
  localparam int TW    = $clog2(TICKS + 1);

  logic [AW-1:0]         ptr;
  logic [HW-1:0]         hiBits;
  logic [7:0]            mem     [MEM_BYTES];
  logic [7:0]            pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pageValid;
  logic                  dirty;
  logic                  busyQ;
  logic [TW-1:0]         tick;
  logic                  commitRun;
  logic [PW-1:0]         commitIdx;
  logic [AW-PW-1:0]      commitPage;

  // Pointer: loaded from two bytes, page-local advance on writes, full advance on reads.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr    <= '0;
      hiBits <= '0;
    end else begin
      if (stb.loadHi) begin
        hiBits <= stb.byteVal[HW-1:0];
      end
      if (stb.loadLo) begin
        ptr <= {hiBits, stb.byteVal};
      end else if (stb.wrData) begin
        ptr <= {ptr[AW-1:PW], ptr[PW-1:0] + 1'b1};
      end else if (stb.rdAdv) begin
        ptr <= ptr + 1'b1;
      end
    end
  end

  // One staging slot per page position.
  for (genvar s = 0; s < PAGE_BYTES; s++) begin : g_slot
    logic hit;
    assign hit = stb.wrData && (ptr[PW-1:0] == PW'(s));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pageValid[s] <= 1'b0;
      end else if (stb.devWrite) begin
        pageValid[s] <= 1'b0;
      end else if (hit) begin
        pageValid[s] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (hit) begin
        pageBuf[s] <= stb.byteVal;
      end
    end
  end

  // Write cycle: starts on STOP, drains one slot per clock, stays busy for TICKS clocks.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirty      <= 1'b0;
      busyQ      <= 1'b0;
      tick       <= '0;
      commitRun  <= 1'b0;
      commitIdx  <= '0;
      commitPage <= '0;
    end else begin
      if (stb.devWrite || stb.stopSeen) begin
        dirty <= 1'b0;
      end else if (stb.wrData) begin
        dirty <= 1'b1;
      end

      if (!busyQ) begin
        if (stb.stopSeen && dirty && !writeProtect) begin
          busyQ      <= 1'b1;
          tick       <= '0;
          commitRun  <= 1'b1;
          commitIdx  <= '0;
          commitPage <= ptr[AW-1:PW];
        end
      end else begin
        tick <= tick + 1'b1;
        if (tick == TW'(TICKS - 1)) begin
          busyQ <= 1'b0;
        end
        if (commitRun) begin
          commitIdx <= commitIdx + 1'b1;
          if (commitIdx == PW'(PAGE_BYTES - 1)) begin
            commitRun <= 1'b0;
          end
        end
      end
    end
  end

  logic commitWe;
  assign commitWe = commitRun && pageValid[commitIdx];

  always_ff @(posedge clk) begin
    if (commitWe) begin
      mem[{commitPage, commitIdx}] <= pageBuf[commitIdx];
    end
  end

  assign rdData = mem[ptr];
  assign busy   = busyQ;
  assign curPtr = ptr;

endmodule

// File: rtl/eeprom_i2c_target.sv
module eeprom_i2c_target
  import eep_pkg::*;
#(
  parameter int MEM_BYTES   = 4096,
  parameter int PAGE_BYTES  = 32,
  parameter int WRITE_TICKS = 300000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaOe,
  input  logic [2:0] strap,
  input  logic       writeProtect
);

  localparam int AW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);

  ctrlStrobe_t   stb;
  logic          busy;
  logic          sclLevel;
  logic [7:0]    rdData;
  logic [AW-1:0] curPtr;

  eep_bus_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .strap    (strap),
    .busy     (busy),
    .rdData   (rdData),
    .sdaOe    (sdaOe),
    .sclLevel (sclLevel),
    .stb      (stb)
  );

  eep_datapath #(
    .MEM_BYTES   (MEM_BYTES),
    .PAGE_BYTES  (PAGE_BYTES),
    .WRITE_TICKS (WRITE_TICKS)
  ) u_data (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .writeProtect (writeProtect),
    .rdData       (rdData),
    .busy         (busy),
    .curPtr       (curPtr)
  );

endmodule

// File: rtl/eep_checker.sv
module eep_checker
  import eep_pkg::*;
#(
  parameter int AW = 12,
  parameter int PW = 5
) (
  input logic          clk,
  input logic          rstN,
  input logic          sdaOe,
  input logic          sclLevel,
  input logic          writeProtect,
  input logic          busy,
  input ctrlStrobe_t   stb,
  input logic [AW-1:0] curPtr
);

  p_oe_scl_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclLevel);

  p_low_addr_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadLo |=> curPtr[7:0] == $past(stb.byteVal));

  p_read_advance_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdAdv |=> curPtr == $past(curPtr) + 1'b1);

  p_page_locked_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrData |=> curPtr[AW-1:PW] == $past(curPtr[AW-1:PW]));

  p_busy_no_ack_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !stb.devWrite);

  p_wp_blocks_r10: assert property (@(posedge clk) disable iff (!rstN)
    (writeProtect && !busy) |=> !busy);

endmodule

bind eeprom_i2c_target eep_checker #(.AW(AW), .PW(PW)) u_checker (
  .clk          (clk),
  .rstN         (rstN),
  .sdaOe        (sdaOe),
  .sclLevel     (sclLevel),
  .writeProtect (writeProtect),
  .busy         (busy),
  .stb          (stb),
  .curPtr       (curPtr)
);

// File: tb/tb_eeprom_i2c_target.sv
module tb_eeprom_i2c_target;

  localparam int CLK_PERIOD = 10;
  localparam int MEM        = 4096;
  localparam int WT         = 2000;
  localparam int Q          = 10;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  logic rstN;
  logic mScl, mLow, wp, quiet, done;
  logic sdaOe, sdaBus;

  int checks = 0;
  int fails  = 0;

  logic [7:0] model  [MEM];
  logic [7:0] txData [64];
  int ptrModel = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign sdaBus = ~(mLow | sdaOe);

  eeprom_i2c_target #(
    .MEM_BYTES   (MEM),
    .PAGE_BYTES  (32),
    .WRITE_TICKS (WT)
  ) dut (
    .clk          (clk),
    .rstN         (rstN),
    .sclIn        (mScl),
    .sdaIn        (sdaBus),
    .sdaOe        (sdaOe),
    .strap        (STRAP),
    .writeProtect (wp)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Per-clock model comparison: slave must stay silent while the master drives.
  always @(negedge clk) begin
    if (quiet && rstN) check(sdaOe == 1'b0, "R3 slave silent while master drives", int'(sdaOe), 0);
  end

  task automatic i2cStart();
    mLow = 1'b0;
    tick(Q);
    mScl = 1'b1;
    tick(2 * Q);
    mLow = 1'b1;
    tick(2 * Q);
    mScl = 1'b0;
  endtask

  task automatic i2cStop();
    tick(Q);
    mLow = 1'b1;
    tick(Q);
    mScl = 1'b1;
    tick(2 * Q);
    mLow = 1'b0;
    tick(2 * Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      mLow  = ~b[i];
      quiet = 1'b1;
      tick(Q);
      mScl = 1'b1;
      tick(2 * Q);
      mScl = 1'b0;
    end
    quiet = 1'b0;
    tick(Q);
    mLow = 1'b0;
    tick(Q);
    mScl = 1'b1;
    tick(Q);
    acked = (sdaBus == 1'b0);
    tick(Q);
    mScl = 1'b0;
  endtask

  task automatic recvByte(input bit ackIt, output logic [7:0] b);
    mLow = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      tick(2 * Q);
      mScl = 1'b1;
      tick(Q);
      b[i] = sdaBus;
      tick(Q);
      mScl = 1'b0;
    end
    tick(Q);
    mLow  = ackIt;
    quiet = 1'b1;
    tick(Q);
    mScl = 1'b1;
    tick(2 * Q);
    mScl  = 1'b0;
    quiet = 1'b0;
    tick(Q);
    mLow = 1'b0;
    if (!ackIt) check(sdaOe == 1'b0, "R11 released after master NACK", int'(sdaOe), 0);
  endtask

  task automatic writeTx(input int addr, input int n, input bit prot);
    bit a;
    int base;
    logic [7:0] stage [32];
    bit used [32];
    base = addr % MEM;
    for (int k = 0; k < 32; k++) used[k] = 1'b0;
    i2cStart();
    sendByte({4'b1010, STRAP, 1'b0}, a);
    check(a, "R2 write address acked", int'(a), 1);
    sendByte(8'((addr >> 8) & 8'hFF), a);
    check(a, "R4 pointer high acked", int'(a), 1);
    sendByte(8'(addr & 8'hFF), a);
    check(a, "R4 pointer low acked", int'(a), 1);
    for (int k = 0; k < n; k++) begin
      int off;
      sendByte(txData[k], a);
      check(a, prot ? "R10 data acked under protect" : "R7 data byte acked", int'(a), 1);
      off = ((base % 32) + k) % 32;
      stage[off] = txData[k];
      used[off]  = 1'b1;
    end
    i2cStop();
    if (!prot && n > 0) begin
      for (int k = 0; k < 32; k++) if (used[k]) model[(base / 32) * 32 + k] = stage[k];
    end
    ptrModel = (base & ~31) | ((base + n) & 31);
  endtask

  task automatic pollExpect(input bit expAck, input string req);
    bit a;
    i2cStart();
    sendByte({4'b1010, STRAP, 1'b0}, a);
    check(a == expAck, req, int'(a), int'(expAck));
    i2cStop();
  endtask

  task automatic pollBusy();
    pollExpect(1'b0, "R9 no ack during write cycle");
    tick(WT + 200);
    pollExpect(1'b1, "R9 ack after write cycle");
  endtask

  task automatic randRead(input int addr, input int n, input string req);
    bit a;
    logic [7:0] b;
    i2cStart();
    sendByte({4'b1010, STRAP, 1'b0}, a);
    check(a, "R12 write address acked", int'(a), 1);
    sendByte(8'((addr >> 8) & 8'hFF), a);
    check(a, "R4 pointer high acked", int'(a), 1);
    sendByte(8'(addr & 8'hFF), a);
    check(a, "R4 pointer low acked", int'(a), 1);
    i2cStart();
    sendByte({4'b1010, STRAP, 1'b1}, a);
    check(a, "R12 read address after repeated START acked", int'(a), 1);
    for (int k = 0; k < n; k++) begin
      int ea;
      recvByte(k != n - 1, b);
      ea = (addr + k) % MEM;
      check(b == model[ea], req, int'(b), int'(model[ea]));
    end
    i2cStop();
    ptrModel = (addr + n) % MEM;
  endtask

  task automatic curRead(input int n, input string req);
    bit a;
    logic [7:0] b;
    i2cStart();
    sendByte({4'b1010, STRAP, 1'b1}, a);
    check(a, "R2 read address acked", int'(a), 1);
    for (int k = 0; k < n; k++) begin
      recvByte(k != n - 1, b);
      check(b == model[ptrModel], req, int'(b), int'(model[ptrModel]));
      ptrModel = (ptrModel + 1) % MEM;
    end
    i2cStop();
  endtask

  initial begin
    bit a;
    done  = 1'b0;
    mScl  = 1'b1;
    mLow  = 1'b0;
    quiet = 1'b0;
    wp    = 1'b0;
    rstN  = 1'b0;
    for (int k = 0; k < MEM; k++) model[k] = 8'h00;
    tick(5);
    check(sdaOe == 1'b0, "R1 released in reset", int'(sdaOe), 0);
    rstN = 1'b1;
    tick(5);
    check(sdaOe == 1'b0, "R1 released after reset", int'(sdaOe), 0);

    // R2: wrong strap bits, then wrong type bits
    i2cStart();
    sendByte({4'b1010, 3'b100, 1'b0}, a);
    check(!a, "R2 wrong strap not acked", int'(a), 0);
    i2cStop();
    i2cStart();
    sendByte({4'b1011, STRAP, 1'b0}, a);
    check(!a, "R2 wrong type bits not acked", int'(a), 0);
    i2cStop();

    // R8: pointer only, no data: no write cycle
    writeTx(16'h0010, 0, 1'b0);
    pollExpect(1'b1, "R8 no cycle without data");

    // R8/R9/R5: small write then sequential read
    txData[0] = 8'h11; txData[1] = 8'h22; txData[2] = 8'h33; txData[3] = 8'h44;
    writeTx(16'h0123, 4, 1'b0);
    pollBusy();
    randRead(16'h0123, 4, "R5 sequential read data");

    // R4: upper pointer bits dropped
    txData[0] = 8'h5A;
    writeTx(16'hF345, 1, 1'b0);
    pollBusy();
    randRead(16'h0345, 1, "R4 upper bits ignored");

    // R7: 36 bytes from offset 28 of page 0x200
    for (int k = 0; k < 36; k++) txData[k] = 8'(8'h80 + k);
    writeTx(16'h021C, 36, 1'b0);
    pollBusy();
    randRead(16'h0200, 32, "R7 page wrap overwrite");

    // R10: protected write
    wp = 1'b1;
    txData[0] = 8'hEE; txData[1] = 8'hDD;
    writeTx(16'h0123, 2, 1'b1);
    pollExpect(1'b1, "R10 no cycle under protect");
    randRead(16'h0123, 2, "R10 array unchanged");
    wp = 1'b0;

    // R6: read across the last location, then R5 current-address continuation
    txData[0] = 8'hC3;
    writeTx(16'h0FFF, 1, 1'b0);
    pollBusy();
    txData[0] = 8'h01; txData[1] = 8'h02; txData[2] = 8'h03;
    writeTx(16'h0000, 3, 1'b0);
    pollBusy();
    randRead(16'h0FFF, 3, "R6 wrap to location 0");
    curRead(1, "R5 current address continues");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule